// File: doc/BRIEF.md
# Base Address Register Sizing Block

This block holds the six base address registers and the expansion ROM base register of one function's configuration space. Its write port takes a byte offset, an access width and a data word. Its read port returns the dword at a given dword index, through combinational logic. Firmware uses it to find how large each decoded region is, by writing all ones and reading back the size mask. It also uses the block to move I/O regions.

Bit 0 of each register's stored value sets its kind. A one means an I/O region and a zero means a memory region. An I/O register takes any ordinary write as its new base. It then reports the move as a one-cycle remap event that carries the register index, the old 16-bit port base and the new one. A memory register cannot be moved: any ordinary write puts back the value it held at reset. Each register has a power-of-two size parameter. A size of zero marks the slot as empty.

Top module: `barcfg_regs`

## Requirements
- R1: After reset, each base register reads its parameter init value, the ROM register reads ROM_ADDR (zero when ROM_SIZE is 0), and remap_valid is 0.
- R2: A word write (wr_width 2, wr_off[1:0] = 0) to dword index 4+i of a present register, whose data satisfies (data | 3 | (size−1)) = all ones, is a sizing probe. From the next cycle the register reads ~(size−1) OR its stored bit 0, and no remap event is raised.
- R3: A non-probe word write to a present register whose stored bit 0 is 0 makes it read its reset value again and ends any probe view.
- R4: A non-probe word write of D to a present register whose stored bit 0 is 1 makes it read D | 1 from the next cycle.
- R5: The write of R4 raises remap_valid for one cycle, in the cycle after the write. With it, remap_bar = i, remap_from = old stored value[15:0] & 0xFFFE and remap_to = D[15:0] & 0xFFFE.
- R6: A probe does not change the stored base of an I/O register, so the remap after a probe reports the base from before the probe.
- R7: A word write to a register whose size parameter is 0 makes it read zero and raises no remap event.
- R8: Byte (wr_width 0), halfword (wr_width 1) and code 3 writes, and word writes whose wr_off[1:0] is not 0, change no register and raise no remap event.
- R9: With ROM_SIZE non-zero, a word write to dword index 12 whose data ORed with 0x7FF is all ones makes the ROM register read −ROM_SIZE. Any other such write makes it read ROM_ADDR. With ROM_SIZE 0 it always reads zero.
- R10: Dword indices other than 4 to 9 and 12 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for this cycle |
| wr_off | input | 8 | Byte offset of the write |
| wr_width | input | 2 | Access width: 0 byte, 1 halfword, 2 word, 3 reserved |
| wr_data | input | 32 | Write data |
| rd_dw | input | 6 | Dword index to read |
| rd_data | output | 32 | Read data for rd_dw |
| remap_valid | output | 1 | One-cycle I/O relocation event |
| remap_bar | output | 3 | Index of the relocated register |
| remap_from | output | 16 | Old port base, bit 0 cleared |
| remap_to | output | 16 | New port base, bit 0 cleared |

## Verification
Each register's state is a stored base plus a probe flag, so a wrong flag appears as a size mask in place of a base on the very next read, or the reverse. A wrong stored base stays hidden under a probe view. It shows only when an ordinary write to an I/O register reports it as remap_from, in the cycle after that write. The probe is therefore followed by a relocation to expose the stored base, and every dword is read back after each write so that corruption cannot wait for a later access.

// File: rtl/barcfg_pkg.sv
package barcfg_pkg;
    localparam int BAR_COUNT   = 6;
    localparam int IDX_W       = 3;
    localparam int BAR_BASE_DW = 4;   // first register at byte offset 0x10
    localparam int ROM_DW      = 12;  // ROM register at byte offset 0x30
    localparam int PORT_W      = 16;

    typedef enum logic [1:0] {
        ACC_BYTE = 2'd0,
        ACC_HALF = 2'd1,
        ACC_WORD = 2'd2,
        ACC_RSVD = 2'd3
    } acc_e;

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  bar;
        logic [PORT_W-1:0] from;
        logic [PORT_W-1:0] to;
    } remap_t;

    function automatic logic [31:0] size_mask(input logic [31:0] size);
        return ~(size - 32'd1);
    endfunction

    function automatic logic is_probe(input logic [31:0] data, input logic [31:0] size);
        return (data | 32'd3 | (size - 32'd1)) == 32'hFFFF_FFFF;
    endfunction

    function automatic logic [PORT_W-1:0] port_of(input logic [31:0] v);
        return v[PORT_W-1:0] & ~PORT_W'(1);
    endfunction
endpackage

// File: rtl/barcfg_slot.sv
module barcfg_slot
    import barcfg_pkg::*;
#(
    parameter logic [31:0] SIZE = 32'd0,
    parameter logic [31:0] INIT = 32'd0,
    parameter int          IDX  = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [31:0] wdata,
    output logic [31:0] view,
    output remap_t      ev
);
    localparam bit PRESENT = (SIZE != 32'd0);

    logic [31:0] base_q;

    generate
        if (PRESENT) begin : g_live
            logic probing_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    base_q    <= INIT;
                    probing_q <= 1'b0;
                    ev        <= '0;
                end else begin
                    ev <= '0;
                    if (wr) begin
                        if (is_probe(wdata, SIZE)) begin
                            probing_q <= 1'b1;
                        end else begin
                            probing_q <= 1'b0;
                            if (base_q[0]) begin
                                base_q <= wdata | 32'd1;
                                ev     <= '{valid: 1'b1, bar: IDX_W'(IDX),
                                            from: port_of(base_q), to: port_of(wdata)};
                            end else begin
                                base_q <= INIT;
                            end
                        end
                    end
                end
            end
            assign view = probing_q ? (size_mask(SIZE) | {31'd0, base_q[0]}) : base_q;
        end else begin : g_absent
            logic unused_data;
            assign unused_data = ^wdata;
            always_ff @(posedge clk) begin
                if (rst)     base_q <= INIT;
                else if (wr) base_q <= '0;
            end
            assign view = base_q;
            assign ev   = '0;
        end
    endgenerate
endmodule

// File: rtl/barcfg_rom.sv
module barcfg_rom
    import barcfg_pkg::*;
#(
    parameter logic [31:0] SIZE = 32'd0,
    parameter logic [31:0] ADDR = 32'd0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [31:0] wdata,
    output logic [31:0] view
);
    generate
        if (SIZE != 32'd0) begin : g_live
            logic probing_q;
            always_ff @(posedge clk) begin
                if (rst)     probing_q <= 1'b0;
                else if (wr) probing_q <= ((wdata | 32'h7FF) == 32'hFFFF_FFFF);
            end
            assign view = probing_q ? (32'd0 - SIZE) : ADDR;
        end else begin : g_absent
            logic unused_in;
            assign unused_in = ^{clk, rst, wr, wdata};
            assign view      = '0;
        end
    endgenerate
endmodule

// File: rtl/barcfg_regs.sv
module barcfg_regs
    import barcfg_pkg::*;
#(
    // register i sits at bits [32*i +: 32]; sizes must be powers of two, 0 = empty
    parameter logic [BAR_COUNT*32-1:0] BAR_SIZES = {32'd0, 32'd4, 32'd0,
                                                   32'h0010_0000, 32'h0000_1000, 32'd32},
    parameter logic [BAR_COUNT*32-1:0] BAR_INITS = {32'd0, 32'h0000_C101, 32'd0,
                                                   32'hFEC0_0008, 32'hFEB0_0000, 32'h0000_C001},
    parameter logic [31:0] ROM_SIZE = 32'h0001_0000,
    parameter logic [31:0] ROM_ADDR = 32'hFEA0_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [7:0]  wr_off,
    input  logic [1:0]  wr_width,
    input  logic [31:0] wr_data,
    input  logic [5:0]  rd_dw,
    output logic [31:0] rd_data,
    output logic        remap_valid,
    output logic [2:0]  remap_bar,
    output logic [15:0] remap_from,
    output logic [15:0] remap_to
);
    logic        word_wr;
    logic [31:0] views [BAR_COUNT];
    remap_t      evs   [BAR_COUNT];
    logic [31:0] rom_view;
    remap_t      merged;

    assign word_wr = wr_en && (acc_e'(wr_width) == ACC_WORD) && (wr_off[1:0] == 2'b00);

    genvar gi;
    generate
        for (gi = 0; gi < BAR_COUNT; gi++) begin : g_bar
            localparam logic [5:0] SLOT_DW = 6'(BAR_BASE_DW + gi);
            logic hit;
            assign hit = word_wr && (wr_off[7:2] == SLOT_DW);
            barcfg_slot #(
                .SIZE(BAR_SIZES[32*gi +: 32]),
                .INIT(BAR_INITS[32*gi +: 32]),
                .IDX (gi)
            ) u_slot (
                .clk  (clk),
                .rst  (rst),
                .wr   (hit),
                .wdata(wr_data),
                .view (views[gi]),
                .ev   (evs[gi])
            );
        end
    endgenerate

    barcfg_rom #(.SIZE(ROM_SIZE), .ADDR(ROM_ADDR)) u_rom (
        .clk  (clk),
        .rst  (rst),
        .wr   (word_wr && (wr_off[7:2] == 6'(ROM_DW))),
        .wdata(wr_data),
        .view (rom_view)
    );

    // one register written per cycle, so at most one event is live
    always_comb begin
        merged = '0;
        for (int i = 0; i < BAR_COUNT; i++) merged = remap_t'(merged | evs[i]);
    end

    assign remap_valid = merged.valid;
    assign remap_bar   = merged.bar;
    assign remap_from  = merged.from;
    assign remap_to    = merged.to;

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < BAR_COUNT; i++)
            if (rd_dw == 6'(BAR_BASE_DW + i)) rd_data = views[i];
        if (rd_dw == 6'(ROM_DW)) rd_data = rom_view;
    end
endmodule

// File: rtl/barcfg_regs_chk.sv
module barcfg_regs_chk
    import barcfg_pkg::*;
#(
    parameter logic [31:0] ROM_SIZE = 32'd0,
    parameter logic [31:0] ROM_ADDR = 32'd0
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [7:0]  wr_off,
    input logic [1:0]  wr_width,
    input logic [31:0] wr_data,
    input logic [5:0]  rd_dw,
    input logic [31:0] rd_data,
    input logic        remap_valid,
    input logic [2:0]  remap_bar,
    input logic [15:0] remap_from,
    input logic [15:0] remap_to
);
    logic unused_from;
    assign unused_from = ^remap_from;

    // R1: no event in the first cycle out of reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !remap_valid);

    // R5: an event follows only an aligned word write
    a_r5_event_cause: assert property (@(posedge clk) disable iff (rst)
        remap_valid |-> ($past(wr_en) && $past(wr_width) == 2'd2 && $past(wr_off[1:0]) == 2'b00));

    // R5: new base comes from the written data
    a_r5_event_target: assert property (@(posedge clk) disable iff (rst)
        remap_valid |-> remap_to == ($past(wr_data[15:0]) & 16'hFFFE));

    // R5: index matches the register that was written
    a_r5_event_index: assert property (@(posedge clk) disable iff (rst)
        remap_valid |-> (remap_bar < 3'd6 && $past(wr_off[7:2]) == 6'(remap_bar) + 6'd4));

    // R8: narrow writes never relocate
    a_r8_narrow_silent: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_width != 2'd2) |=> !remap_valid);

    // R9: ROM register shows only its two legal values, or zero when absent
    a_r9_rom_values: assert property (@(posedge clk) disable iff (rst)
        (rd_dw == 6'd12) |-> ((ROM_SIZE == 32'd0) ? (rd_data == 32'd0)
                              : (rd_data == ROM_ADDR || rd_data == 32'd0 - ROM_SIZE)));

    // R10: unmapped dwords read zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_dw < 6'd4 || (rd_dw > 6'd9 && rd_dw != 6'd12)) |-> rd_data == 32'd0);
endmodule

bind barcfg_regs barcfg_regs_chk #(.ROM_SIZE(ROM_SIZE), .ROM_ADDR(ROM_ADDR)) u_chk (.*);

// File: tb/barcfg_regs_test.sv
module barcfg_regs_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_off = '0;
    logic [1:0]  wr_width = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_dw = '0;
    logic [31:0] rd_data;
    logic        remap_valid;
    logic [2:0]  remap_bar;
    logic [15:0] remap_from, remap_to;

    int n_checks = 0;
    int n_fails  = 0;

    localparam logic [31:0] SZ   [6] = '{32'd32, 32'h1000, 32'h10_0000, 32'd0, 32'd4, 32'd0};
    localparam logic [31:0] INIT [6] = '{32'h0000_C001, 32'hFEB0_0000, 32'hFEC0_0008,
                                         32'd0, 32'h0000_C101, 32'd0};
    localparam logic [31:0] RSIZE = 32'h0001_0000;
    localparam logic [31:0] RADDR = 32'hFEA0_0000;

    logic [31:0] m_base [6];
    bit          m_probe [6];
    bit          m_rprobe;

    barcfg_regs uut (.*);

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input int dw);
        if (dw >= 4 && dw <= 9) begin
            if (m_probe[dw-4]) return ~(SZ[dw-4] - 1) | {31'd0, m_base[dw-4][0]};
            return m_base[dw-4];
        end
        if (dw == 12) return m_rprobe ? 32'd0 - RSIZE : RADDR;
        return 32'd0;
    endfunction

    task automatic read_all(input string tag);
        for (int dw = 0; dw < 16; dw++) begin
            rd_dw = 6'(dw);
            #1;
            check(tag, rd_data, exp_read(dw));
        end
    endtask

    // drive at negedge, check registered event at following negedge, then all reads
    task automatic wr(input logic [7:0] off, input logic [1:0] w, input logic [31:0] d,
                      input string tag);
        bit          ev = 0;
        logic [2:0]  ebar = '0;
        logic [15:0] efrom = '0, eto = '0;
        @(negedge clk);
        wr_en = 1'b1; wr_off = off; wr_width = w; wr_data = d;
        if (w == 2'd2 && off[1:0] == 2'b00) begin
            int dw = int'(off[7:2]);
            if (dw >= 4 && dw <= 9) begin
                int i = dw - 4;
                if (SZ[i] == 0) m_base[i] = 32'd0;
                else if ((d | 32'd3 | (SZ[i] - 1)) == 32'hFFFF_FFFF) m_probe[i] = 1;
                else begin
                    m_probe[i] = 0;
                    if (m_base[i][0]) begin
                        ev = 1; ebar = 3'(i);
                        efrom = m_base[i][15:0] & 16'hFFFE;
                        eto   = d[15:0] & 16'hFFFE;
                        m_base[i] = d | 32'd1;
                    end else m_base[i] = INIT[i];
                end
            end
            if (dw == 12) m_rprobe = ((d | 32'h7FF) == 32'hFFFF_FFFF);
        end
        @(negedge clk);
        wr_en = 1'b0;
        check({tag, " R5 valid"}, 32'(remap_valid), 32'(ev));
        if (ev) begin
            check({tag, " R5 bar"},  32'(remap_bar),  32'(ebar));
            check({tag, " R5 from"}, 32'(remap_from), 32'(efrom));
            check({tag, " R5 to"},   32'(remap_to),   32'(eto));
        end
        read_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd48611));
        for (int i = 0; i < 6; i++) begin m_base[i] = INIT[i]; m_probe[i] = 0; end
        m_rprobe = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 no event", 32'(remap_valid), 32'd0);
        read_all("R1");

        // R2 probes on memory and I/O registers
        wr(8'h14, 2'd2, 32'hFFFF_FFFF, "R2 mem probe");
        wr(8'h10, 2'd2, 32'hFFFF_FFFF, "R2 io probe");
        wr(8'h20, 2'd2, 32'hFFFF_FFFE, "R2 io probe size4");
        // R6 relocation after probe reports pre-probe base; R4 reads D|1
        wr(8'h10, 2'd2, 32'h0000_D000, "R6 R4 io move");
        wr(8'h20, 2'd2, 32'h0001_E004, "R4 io move high bits");
        // R3 memory refuses relocation
        wr(8'h18, 2'd2, 32'hFFF0_0000, "R2 mem probe large");
        wr(8'h18, 2'd2, 32'h1234_5000, "R3 mem restore");
        wr(8'h14, 2'd2, 32'h0000_0000, "R3 mem restore zero");
        // R7 empty slots
        wr(8'h1C, 2'd2, 32'hFFFF_FFFF, "R7 empty probe");
        wr(8'h24, 2'd2, 32'h0000_1001, "R7 empty write");
        // R8 narrow and unaligned writes
        wr(8'h10, 2'd0, 32'h0000_0055, "R8 byte");
        wr(8'h12, 2'd1, 32'h0000_ABCD, "R8 half");
        wr(8'h11, 2'd2, 32'h0000_9000, "R8 unaligned word");
        wr(8'h10, 2'd3, 32'h0000_9000, "R8 reserved width");
        wr(8'h30, 2'd1, 32'hFFFF_FFFF, "R8 half rom");
        // R9 ROM probe and restore
        wr(8'h30, 2'd2, 32'hFFFF_F800, "R9 rom probe");
        wr(8'h30, 2'd2, 32'hFFFF_F000, "R9 rom not probe");
        // R10 other offsets
        wr(8'h04, 2'd2, 32'hFFFF_FFFF, "R10 other");
        wr(8'h2C, 2'd2, 32'h1111_1111, "R10 above window");

        for (int n = 0; n < 500; n++) begin
            logic [7:0]  off;
            logic [1:0]  w;
            logic [31:0] d;
            off = 8'($urandom_range(0, 15) * 4);
            if ($urandom_range(0, 9) == 0) off = off + 8'($urandom_range(1, 3));
            w = ($urandom_range(0, 4) < 3) ? 2'd2 : 2'($urandom_range(0, 3));
            case ($urandom_range(0, 2))
                0:       d = 32'hFFFF_FFFF & ~(32'd1 << $urandom_range(0, 12));
                1:       d = 32'hFFFF_FFFF;
                default: d = $urandom;
            endcase
            wr(off, w, d, "RAND R2 R3 R4 R7 R8 R9 R10");
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule